// File: doc/BRIEF.md
# Multi-Block Erase Selection Window

This block collects the set of blocks that one flash erase operation will clear. The command decoder ahead of it turns bus writes into single-cycle pulses: a block-erase confirm carrying a block index, a suspend, a resume, and a pulse for any other command. It also supplies a flag that says whether the address on a suspend or resume names the bank that is erasing. A bitmap gives the protection status of every block.

The first confirm opens a hold window. Every further confirm that lands inside the window adds its block to the selection and starts the window over. When the window runs out with no new confirm, the block pulses a start request to the erase engine and keeps the selection bitmap stable for it. If every named block was protected, no erase is requested. After a fixed delay the block pulses an abort instead.

A suspend can arrive during the window or during the erase. A suspend in the window freezes the selection, and the matching resume reopens a full-length window in which more blocks may still be added. A suspend during the erase holds the selection until the resume. A completion pulse from the engine then clears it.

Top module: `erase_sel_window`

## Requirements
- R1: The first confirm opens the window. `eraseStart` goes high for one cycle exactly HOLD_CYC clock edges after the edge that sampled the last confirm, with the selected blocks set in `selMap`.
- R2: A confirm sampled while the window is open sets bit `blkAddr` of `selMap` and restarts the full HOLD_CYC count. `selMap` never gains a bit in a cycle without a confirm.
- R3: A confirm for a block whose `protMask` bit is 1 (1 = protected) adds nothing to `selMap`.
- R4: If the window expires with `selMap` empty, no start is issued. `allProtAbort` pulses for one cycle exactly ABORT_CYC edges after the expiry edge, and the block returns to idle.
- R5: `otherCmd` during an open window clears `selMap`, cancels the start, and returns to idle.
- R6: A suspend with `bankHit`=1 during the window freezes it: no start follows while suspended. A resume with `bankHit`=1 reopens a full HOLD_CYC window with the earlier selection kept, and further confirms may be added.
- R7: Once the erase runs, confirms and `otherCmd` are ignored. A suspend with `bankHit`=1 pauses it, and `eraseDone` is ignored until a resume with `bankHit`=1 returns to the running erase.
- R8: A suspend or resume with `bankHit`=0 is ignored in every state. A suspend while idle is ignored.
- R9: `eraseDone` during a running erase clears `selMap` and returns to idle.
- R10: An active-low `rstN` clears `selMap` at once and holds both pulse outputs low.
- R11: `eraseStart` and `allProtAbort` last one cycle each and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| blkCfm | input | 1 | Decoded block-erase confirm pulse |
| blkAddr | input | $clog2(NUM_BLK) | Block index of the confirm |
| otherCmd | input | 1 | Pulse for any other decoded command |
| suspCmd | input | 1 | Erase suspend pulse |
| resCmd | input | 1 | Erase resume pulse |
| bankHit | input | 1 | Suspend/resume address names the erasing bank |
| eraseDone | input | 1 | Erase engine completion pulse |
| protMask | input | NUM_BLK | Per-block protect status, 1 = protected |
| selMap | output | NUM_BLK | Selected-block bitmap |
| eraseStart | output | 1 | One-cycle start request to the erase engine |
| allProtAbort | output | 1 | One-cycle abort when no block was selectable |

## Verification
The assertions check several rules on every cycle. The two pulses stay single and exclusive. A start never comes with an empty map, and an abort never comes with a non-empty one. The map gains bits only from a confirm, never from a protected one, and no start follows directly on a confirm. The bench scenarios cover the behaviour that depends on time and on the order of commands. These include the exact hold and abort distances, the window restart, the full-length window after a resume, the cancel by another command, and the ignored completion while an erase is suspended. They also cover suspends and resumes aimed at the wrong bank.

// File: rtl/erase_sel_pkg.sv
package erase_sel_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WIN   = 3'd1,
    ST_SUSPW = 3'd2,
    ST_RUN   = 3'd3,
    ST_SUSPR = 3'd4,
    ST_ABORT = 3'd5
  } selState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic addBlk;
    logic clrSel;
    logic ldHold;
    logic ldAbort;
    logic tick;
  } selStrobe_t;

endpackage

// File: rtl/erase_sel_dp.sv
module erase_sel_dp
  import erase_sel_pkg::*;
#(
  parameter int NUM_BLK   = 16,
  parameter int HOLD_CYC  = 5000,
  parameter int ABORT_CYC = 10000
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  selStrobe_t                 stb,
  input  logic [$clog2(NUM_BLK)-1:0] blkAddr,
  input  logic [NUM_BLK-1:0]         protMask,
  output logic [NUM_BLK-1:0]         selMap,
  output logic                       cntZero,
  output logic                       selAny
);
  localparam int BLK_W   = $clog2(NUM_BLK);
  localparam int CNT_MAX = (HOLD_CYC > ABORT_CYC) ? HOLD_CYC : ABORT_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] HOLD_LD  = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] ABORT_LD = CNT_W'(ABORT_CYC - 1);

  logic [CNT_W-1:0] cnt;

  // one flop per block; a bit is set only for an unprotected confirm
  for (genvar i = 0; i < NUM_BLK; i++) begin : g_blk
    logic hitBlk;
    assign hitBlk = stb.addBlk && (blkAddr == BLK_W'(i)) && !protMask[i];
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)           selMap[i] <= 1'b0;
      else if (stb.clrSel) selMap[i] <= 1'b0;
      else if (hitBlk)     selMap[i] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         cnt <= '0;
    else if (stb.ldHold)               cnt <= HOLD_LD;
    else if (stb.ldAbort)              cnt <= ABORT_LD;
    else if (stb.tick && cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign cntZero = (cnt == '0);
  assign selAny  = |selMap;

endmodule

// File: rtl/erase_sel_ctrl.sv
module erase_sel_ctrl
  import erase_sel_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       blkCfm,
  input  logic       otherCmd,
  input  logic       suspCmd,
  input  logic       resCmd,
  input  logic       bankHit,
  input  logic       eraseDone,
  input  logic       cntZero,
  input  logic       selAny,
  output selStrobe_t stb,
  output logic       eraseStart,
  output logic       allProtAbort
);
  selState_e state, stateNxt;
  logic startNxt, abortNxt, suspOk, resOk;

  assign suspOk = suspCmd && bankHit;
  assign resOk  = resCmd && bankHit;

  always_comb begin
    stateNxt = state;
    stb      = '0;
    startNxt = 1'b0;
    abortNxt = 1'b0;
    case (state)
      ST_IDLE: begin
        if (blkCfm) begin
          stb.addBlk = 1'b1;
          stb.ldHold = 1'b1;
          stateNxt   = ST_WIN;
        end
      end
      ST_WIN: begin
        if (otherCmd) begin
          stb.clrSel = 1'b1;
          stateNxt   = ST_IDLE;
        end else if (suspOk) begin
          stateNxt = ST_SUSPW;
        end else if (blkCfm) begin
          stb.addBlk = 1'b1;
          stb.ldHold = 1'b1;
        end else if (cntZero) begin
          if (selAny) begin
            startNxt = 1'b1;
            stateNxt = ST_RUN;
          end else begin
            stb.ldAbort = 1'b1;
            stateNxt    = ST_ABORT;
          end
        end else begin
          stb.tick = 1'b1;
        end
      end
      ST_SUSPW: begin
        if (resOk) begin
          stb.ldHold = 1'b1;
          stateNxt   = ST_WIN;
        end
      end
      ST_RUN: begin
        if (suspOk) begin
          stateNxt = ST_SUSPR;
        end else if (eraseDone) begin
          stb.clrSel = 1'b1;
          stateNxt   = ST_IDLE;
        end
      end
      ST_SUSPR: begin
        if (resOk) stateNxt = ST_RUN;
      end
      ST_ABORT: begin
        if (cntZero) begin
          abortNxt   = 1'b1;
          stb.clrSel = 1'b1;
          stateNxt   = ST_IDLE;
        end else begin
          stb.tick = 1'b1;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state        <= ST_IDLE;
      eraseStart   <= 1'b0;
      allProtAbort <= 1'b0;
    end else begin
      state        <= stateNxt;
      eraseStart   <= startNxt;
      allProtAbort <= abortNxt;
    end
  end

endmodule

// File: rtl/erase_sel_window.sv
module erase_sel_window
  import erase_sel_pkg::*;
#(
  parameter int NUM_BLK   = 16,
  parameter int HOLD_CYC  = 5000,
  parameter int ABORT_CYC = 10000
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       blkCfm,
  input  logic [$clog2(NUM_BLK)-1:0] blkAddr,
  input  logic                       otherCmd,
  input  logic                       suspCmd,
  input  logic                       resCmd,
  input  logic                       bankHit,
  input  logic                       eraseDone,
  input  logic [NUM_BLK-1:0]         protMask,
  output logic [NUM_BLK-1:0]         selMap,
  output logic                       eraseStart,
  output logic                       allProtAbort
);
  selStrobe_t stb;
  logic cntZero, selAny;

  erase_sel_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .blkCfm(blkCfm), .otherCmd(otherCmd),
    .suspCmd(suspCmd), .resCmd(resCmd), .bankHit(bankHit),
    .eraseDone(eraseDone), .cntZero(cntZero), .selAny(selAny),
    .stb(stb), .eraseStart(eraseStart), .allProtAbort(allProtAbort)
  );

  erase_sel_dp #(
    .NUM_BLK(NUM_BLK), .HOLD_CYC(HOLD_CYC), .ABORT_CYC(ABORT_CYC)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .blkAddr(blkAddr),
    .protMask(protMask), .selMap(selMap), .cntZero(cntZero), .selAny(selAny)
  );

endmodule

// File: rtl/erase_sel_window_chk.sv
module erase_sel_window_chk #(
  parameter int NUM_BLK = 16
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       blkCfm,
  input logic [$clog2(NUM_BLK)-1:0] blkAddr,
  input logic [NUM_BLK-1:0]         protMask,
  input logic [NUM_BLK-1:0]         selMap,
  input logic                       eraseStart,
  input logic                       allProtAbort
);
  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    eraseStart |=> !eraseStart);                                   // R11
  AST_ABORT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    allProtAbort |=> !allProtAbort);                               // R11
  AST_PULSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(eraseStart && allProtAbort));                                // R11
  AST_START_HAS_SEL: assert property (@(posedge clk) disable iff (!rstN)
    eraseStart |-> (selMap != '0));                                // R1
  AST_START_AFTER_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    eraseStart |-> !$past(blkCfm));                                // R1
  AST_ABORT_EMPTY_SEL: assert property (@(posedge clk) disable iff (!rstN)
    allProtAbort |-> (selMap == '0));                              // R4
  AST_GROW_ONLY_ON_CFM: assert property (@(posedge clk) disable iff (!rstN)
    !blkCfm |=> ((selMap & ~$past(selMap)) == '0));                // R2
  AST_PROT_NOT_ADDED: assert property (@(posedge clk) disable iff (!rstN)
    (blkCfm && protMask[blkAddr]) |=> ((selMap & ~$past(selMap)) == '0)); // R3
endmodule

bind erase_sel_window erase_sel_window_chk #(.NUM_BLK(NUM_BLK)) u_chk (
  .clk(clk), .rstN(rstN), .blkCfm(blkCfm), .blkAddr(blkAddr),
  .protMask(protMask), .selMap(selMap), .eraseStart(eraseStart),
  .allProtAbort(allProtAbort)
);

// File: tb/erase_sel_window_bench.sv
`timescale 1ns/1ps
module erase_sel_window_bench;
  localparam int NB = 8;
  localparam int HC = 3;
  localparam int AC = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic blkCfm = 0, otherCmd = 0, suspCmd = 0, resCmd = 0, bankHit = 0, eraseDone = 0;
  logic [2:0] blkAddr = '0;
  logic [NB-1:0] protMask = 8'h80;
  logic [NB-1:0] selMap;
  logic eraseStart, allProtAbort;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  erase_sel_window #(.NUM_BLK(NB), .HOLD_CYC(HC), .ABORT_CYC(AC)) u_erase_sel_window (
    .clk(clk), .rstN(rstN), .blkCfm(blkCfm), .blkAddr(blkAddr),
    .otherCmd(otherCmd), .suspCmd(suspCmd), .resCmd(resCmd), .bankHit(bankHit),
    .eraseDone(eraseDone), .protMask(protMask), .selMap(selMap),
    .eraseStart(eraseStart), .allProtAbort(allProtAbort)
  );

  typedef struct packed {
    logic       cfm;
    logic [2:0] addr;
    logic       oth, sus, res, bok, done;
    logic       eStart, eAbort;
    logic [7:0] eMap;
    logic [7:0] req;
  } vec_t;

  localparam int NVEC = 36;
  // cfm addr oth sus res bok done | start abort map | req   (block 7 protected)
  localparam vec_t TBL [NVEC] = '{
    '{1'b1,3'd2,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,8'h04, 8'd1},  // R1 open window
    '{1'b0,3'd0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,8'h04, 8'd1},
    '{1'b1,3'd5,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,8'h24, 8'd2},  // R2 add + restart
    '{1'b0,3'd0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,8'h24, 8'd2},
    '{1'b0,3'd0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,8'h24, 8'd2},
    '{1'b0,3'd0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0,8'h24, 8'd1},  // R1 start
    '{1'b1,3'd1,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,8'h24, 8'd7},  // R7 cfm ignored
    '{1'b0,3'd0,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,8'h24, 8'd7},  // R7 other ignored
    '{1'b0,3'd0,1'b0,1'b0,1'b0,1'b0,1'b1, 1'b0,1'b0,8'h00, 8'd9},  // R9 done
    '{1'b1,3'd7,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,8'h00, 8'd3},  // R3 protected
    '{1'b0,3'd0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,8'h00, 8'd4},
    '{1'b0,3'd0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,8'h00, 8'd4},
    '{1'b0,3'd0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,8'h00, 8'd4},  // R4 expiry, no start
    '{1'b0,3'd0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,8'h00, 8'd4},
    '{1'b0,3'd0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,8'h00, 8'd4},
    '{1'b0,3'd0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,8'h00, 8'd4},
    '{1'b0,3'd0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,8'h00, 8'd4},
    '{1'b0,3'd0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b1,8'h00, 8'd4},  // R4 abort
    '{1'b0,3'd0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,8'h00, 8'd11}, // R11 one cycle
    '{1'b1,3'd3,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,8'h08, 8'd1},
    '{1'b0,3'd0,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,8'h00, 8'd5},  // R5 cancel
    '{1'b0,3'd0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,8'h00, 8'd5},
    '{1'b0,3'd0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,8'h00, 8'd5},
    '{1'b1,3'd0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,8'h01, 8'd1},
    '{1'b0,3'd0,1'b0,1'b1,1'b0,1'b1,1'b0, 1'b0,1'b0,8'h01, 8'd6},  // R6 suspend window
    '{1'b0,3'd0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,8'h01, 8'd6},
    '{1'b0,3'd0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,8'h01, 8'd6},
    '{1'b0,3'd0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,8'h01, 8'd6},
    '{1'b0,3'd0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,8'h01, 8'd6},
    '{1'b0,3'd0,1'b0,1'b0,1'b1,1'b1,1'b0, 1'b0,1'b0,8'h01, 8'd6},  // R6 resume
    '{1'b1,3'd6,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,8'h41, 8'd6},  // R6 add after resume
    '{1'b0,3'd0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,8'h41, 8'd6},
    '{1'b0,3'd0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,8'h41, 8'd6},
    '{1'b0,3'd0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0,8'h41, 8'd6},
    '{1'b0,3'd0,1'b0,1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0,8'h41, 8'd8},  // R8 wrong bank
    '{1'b0,3'd0,1'b0,1'b0,1'b0,1'b0,1'b1, 1'b0,1'b0,8'h00, 8'd8}   // R8 done honoured
  };

  task automatic chk(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic c, input logic [2:0] a, input logic o, input logic s,
                      input logic r, input logic b, input logic d);
    blkCfm = c; blkAddr = a; otherCmd = o; suspCmd = s; resCmd = r; bankHit = b; eraseDone = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    step(0, 3'd0, 0, 0, 0, 0, 0);
  endtask

  task automatic outs(input int req, input logic st, input logic ab, input logic [7:0] mp);
    chk(req, "eraseStart", 32'(eraseStart), 32'(st));
    chk(req, "allProtAbort", 32'(allProtAbort), 32'(ab));
    chk(req, "selMap", 32'(selMap), 32'(mp));
  endtask

  initial begin
    #160000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    outs(10, 0, 0, 8'h00);                    // R10 reset state
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      step(TBL[i].cfm, TBL[i].addr, TBL[i].oth, TBL[i].sus, TBL[i].res, TBL[i].bok, TBL[i].done);
      outs(int'(TBL[i].req), TBL[i].eStart, TBL[i].eAbort, TBL[i].eMap);
    end

    // R1 single block, then R11 pulse width
    step(1, 3'd4, 0, 0, 0, 0, 0);
    idle(); idle(); idle();
    outs(1, 1, 0, 8'h10);
    idle();
    outs(11, 0, 0, 8'h10);
    // R7 suspend during erase: done ignored while paused
    step(0, 3'd0, 0, 1, 0, 1, 0);
    step(0, 3'd0, 0, 0, 0, 0, 1);
    outs(7, 0, 0, 8'h10);
    // R8 resume for wrong bank ignored
    step(0, 3'd0, 0, 0, 1, 0, 0);
    step(0, 3'd0, 0, 0, 0, 0, 1);
    outs(8, 0, 0, 8'h10);
    step(0, 3'd0, 0, 0, 1, 1, 0);
    step(0, 3'd0, 0, 0, 0, 0, 1);
    outs(9, 0, 0, 8'h00);                     // R9 done after resume

    // R8 suspend while idle ignored
    step(0, 3'd0, 0, 1, 0, 1, 0);
    step(1, 3'd1, 0, 0, 0, 0, 0);
    idle(); idle();
    outs(8, 0, 0, 8'h02);
    idle();
    outs(8, 1, 0, 8'h02);
    step(0, 3'd0, 0, 0, 0, 0, 1);

    // R6 wrong-bank resume in suspended window ignored, then full window
    step(1, 3'd2, 0, 0, 0, 0, 0);
    step(0, 3'd0, 0, 1, 0, 1, 0);
    step(0, 3'd0, 0, 0, 1, 0, 0);
    for (int k = 0; k < 4; k++) begin
      idle();
      outs(6, 0, 0, 8'h04);
    end
    step(0, 3'd0, 0, 0, 1, 1, 0);
    idle(); idle();
    outs(6, 0, 0, 8'h04);
    idle();
    outs(6, 1, 0, 8'h04);
    step(0, 3'd0, 0, 0, 0, 0, 1);

    // R10 reset in the middle of a window
    step(1, 3'd3, 0, 0, 0, 0, 0);
    rstN = 1'b0;
    #1;
    outs(10, 0, 0, 8'h00);
    @(negedge clk);
    rstN = 1'b1;
    for (int k = 0; k < 4; k++) begin
      idle();
      outs(10, 0, 0, 8'h00);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule